// File: doc/BRIEF.md
# Banked ROM Cartridge Mapper with Split-Port RAM

The block sits behind a 13-bit cartridge address bus that has no read/write line. It maps a 64 KiB ROM into the 4 KiB cartridge window as sixteen 4 KiB banks, one bank at a time. A 128-byte RAM occupies the lowest 256 bytes of the window. The lower half of those 256 bytes is the RAM's write port and the upper half is its read port. The active bank changes when software touches a row of sixteen hotspot addresses near the top of the window.

The cartridge cannot tell a read from a write. Every strobed access to the write port therefore latches whatever is on the data bus into RAM. Normally the mapper leaves the bus undriven during that access. A development input makes it drive pseudo-random bytes instead, so that software which reads the write port by mistake misbehaves at once.

The ROM array sits outside the block. The mapper presents a 16-bit ROM address and takes the byte back on the same cycle.

The bus runs at a fixed rate of one access per `bus_strobe`. It has neither valid/ready nor back-pressure, because the processor never stalls. Every port is a plain control or data pin. Outputs are combinational from the address within the strobed cycle. State updates on the clock edge that ends the cycle.

Top module: `cart_bank_mapper`

## Requirements
- R1: An access with `cart_addr[12]` = 0, or any cycle with `bus_strobe` low, leaves `cart_oe` low and changes neither the bank, the RAM nor the LFSR. The one exception is that the LFSR still advances on a strobe outside the window.
- R2: A strobed access to window offsets 0x100-0xFFF drives `cart_oe` high with `cart_dout` = `rom_data`. Here `rom_addr` = {bank[3:0], `cart_addr[11:0]`}.
- R3: A strobed access to offsets 0xFE0-0xFEF selects bank `cart_addr[3:0]` from the next cycle. The hotspot access itself returns ROM data from the previous bank.
- R4: Reset selects bank 0 and reloads the LFSR seed. Reset does not clear the RAM contents.
- R5: Every strobed access to offsets 0x000-0x07F stores `cart_din` into RAM byte `cart_addr[6:0]`, whatever the development mode.
- R6: A strobed write-port access with `dev_rand` = 0 keeps `cart_oe` low.
- R7: A strobed write-port access with `dev_rand` = 1 drives `cart_oe` high with `cart_dout` equal to LFSR bits [7:0] as they stand in that cycle.
- R8: A strobed access to offsets 0x080-0x0FF drives `cart_oe` high with RAM byte `cart_addr[6:0]`. ROM data is never returned there.
- R9: The LFSR is 16 bits wide and shifts right in Galois form with a tap mask of 16'hB400. Its seed is 16'hACE1, and it advances once on every strobed cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_strobe | input | 1 | One pulse per bus access |
| cart_addr | input | 13 | Cartridge address; bit 12 is the window select |
| cart_din | input | 8 | Data seen on the bus |
| cart_dout | output | 8 | Data the cartridge drives |
| cart_oe | output | 1 | High when the cartridge drives the bus |
| dev_rand | input | 1 | Development mode: random data on write-port reads |
| rom_addr | output | 16 | Address into the external ROM |
| rom_data | input | 8 | ROM byte at `rom_addr` |

## Verification
The assertions assume that `cart_addr`, `cart_din` and `dev_rand` stay stable for the whole clock cycle of a strobe. They also assume that `rom_data` follows `rom_addr` within that cycle, as an asynchronous ROM does.

The bench changes inputs only on the falling edge. It feeds `rom_data` from a combinational function of `rom_addr`. It compares the outputs against a behavioural model only after RAM bytes have been written, because RAM contents are undefined after power-up.

// File: rtl/cart_pkg.sv
package cart_pkg;
  typedef enum logic [1:0] {
    RGN_NONE   = 2'd0,
    RGN_RAM_WR = 2'd1,
    RGN_RAM_RD = 2'd2,
    RGN_ROM    = 2'd3
  } cart_region_e;
endpackage

// File: rtl/cart_decode.sv
module cart_decode import cart_pkg::*; #(
  parameter int ADDR_W   = 13,
  parameter int RAM_AW   = 7,
  parameter int BANK_W   = 4,
  parameter int HOT_BASE = 'hFE0
) (
  input  logic [ADDR_W-1:0] addr,
  output cart_region_e      region,
  output logic              hotspot
);
  localparam int OFS_W = ADDR_W - 1;
  localparam logic [OFS_W-1:0] HOT_VEC = OFS_W'(HOT_BASE);

  logic [OFS_W-1:0] ofs;
  logic             in_win;
  logic             ram_zone;

  assign ofs      = addr[OFS_W-1:0];
  assign in_win   = addr[ADDR_W-1];
  assign ram_zone = (ofs[OFS_W-1:RAM_AW+1] == '0);

  always_comb begin
    if (!in_win)            region = RGN_NONE;
    else if (!ram_zone)     region = RGN_ROM;
    else if (ofs[RAM_AW])   region = RGN_RAM_RD;
    else                    region = RGN_RAM_WR;
  end

  assign hotspot = in_win && (ofs[OFS_W-1:BANK_W] == HOT_VEC[OFS_W-1:BANK_W]);
endmodule

// File: rtl/cart_bank_sel.sv
module cart_bank_sel #(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] sel,
  output logic [BANK_W-1:0] bank
);
  always_ff @(posedge clk) begin
    if (!rst_n)    bank <= '0;
    else if (load) bank <= sel;
  end

  p_bank_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bank == $past(sel));
  p_bank_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(bank));
endmodule

// File: rtl/cart_ram.sv
module cart_ram #(
  parameter int AW     = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wr_data;
  end

  assign rd_data = mem[idx];

  p_ram_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem[$past(idx)] == $past(wr_data)));
endmodule

// File: rtl/cart_lfsr.sv
module cart_lfsr #(
  parameter int          W     = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter int          OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] state;
  logic [W-1:0] nxt;

  assign nxt = (state >> 1) ^ (state[0] ? TAPS : '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= nxt;
  end

  assign rnd = state[OUT_W-1:0];

  p_lfsr_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  p_lfsr_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> state != $past(state));
  p_lfsr_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state));
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper import cart_pkg::*; #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int RAM_AW = 7,
  parameter int BANK_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_strobe,
  input  logic [ADDR_W-1:0]         cart_addr,
  input  logic [DATA_W-1:0]         cart_din,
  output logic [DATA_W-1:0]         cart_dout,
  output logic                      cart_oe,
  input  logic                      dev_rand,
  output logic [BANK_W+ADDR_W-2:0]  rom_addr,
  input  logic [DATA_W-1:0]         rom_data
);
  localparam int OFS_W = ADDR_W - 1;

  cart_region_e      region;
  logic              hotspot;
  logic [BANK_W-1:0] bank;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] rnd;

  cart_decode #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .BANK_W(BANK_W)) u_dec (
    .addr(cart_addr), .region(region), .hotspot(hotspot));

  cart_bank_sel #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .load(bus_strobe && hotspot),
    .sel(cart_addr[BANK_W-1:0]), .bank(bank));

  cart_ram #(.AW(RAM_AW), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_strobe && region == RGN_RAM_WR),
    .idx(cart_addr[RAM_AW-1:0]), .wr_data(cart_din), .rd_data(ram_q));

  cart_lfsr #(.OUT_W(DATA_W)) u_rng (
    .clk(clk), .rst_n(rst_n), .step(bus_strobe), .rnd(rnd));

  assign rom_addr = {bank, cart_addr[OFS_W-1:0]};

  always_comb begin
    cart_oe   = 1'b0;
    cart_dout = '0;
    if (bus_strobe) begin
      case (region)
        RGN_RAM_WR: if (dev_rand) begin cart_oe = 1'b1; cart_dout = rnd; end
        RGN_RAM_RD: begin cart_oe = 1'b1; cart_dout = ram_q; end
        RGN_ROM:    begin cart_oe = 1'b1; cart_dout = rom_data; end
        default:    ;
      endcase
    end
  end

  p_outside_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cart_addr[ADDR_W-1] |-> !cart_oe);
  p_wrport_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && !dev_rand && cart_addr[ADDR_W-1] &&
     cart_addr[OFS_W-1:RAM_AW] == '0) |-> !cart_oe);
  p_ramwin_no_rom_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && cart_addr[ADDR_W-1] && cart_addr[OFS_W-1:RAM_AW] == 1)
      |-> (cart_oe && cart_dout == ram_q));
  p_hot_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && hotspot) |=> rom_addr[BANK_W+OFS_W-1:OFS_W] == $past(cart_addr[BANK_W-1:0]));
endmodule

// File: tb/sim_cart_bank_mapper.sv
module sim_cart_bank_mapper;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_strobe = 0;
  logic [12:0] cart_addr = '0;
  logic [7:0]  cart_din = '0;
  logic [7:0]  cart_dout;
  logic        cart_oe;
  logic        dev_rand = 0;
  logic [15:0] rom_addr;
  logic [7:0]  rom_data;

  int total = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] rom_fn(input logic [15:0] a);
    return a[7:0] ^ {a[15:12], a[11:8]} ^ 8'h5A;
  endfunction
  assign rom_data = rom_fn(rom_addr);

  cart_bank_mapper u0 (.*);

  int mbank;
  int mlfsr;
  logic [7:0] mram [128];
  bit mknown [128];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bus_strobe = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    mbank = 0; mlfsr = 'hACE1;
  endtask

  task automatic cyc(input bit stb, input logic [12:0] a, input logic [7:0] d, input bit dev, input string req);
    bit eoe; int edo; bit dknown; int ofs;
    @(negedge clk);
    bus_strobe = stb; cart_addr = a; cart_din = d; dev_rand = dev;
    #1;
    ofs = a[11:0];
    eoe = 0; edo = 0; dknown = 1;
    if (stb && a[12]) begin
      if (ofs < 'h80) begin
        eoe = dev; edo = mlfsr & 'hFF;
      end else if (ofs < 'h100) begin
        eoe = 1; edo = mram[ofs & 'h7F]; dknown = mknown[ofs & 'h7F];
      end else begin
        eoe = 1; edo = rom_fn(16'((mbank << 12) | ofs));
      end
    end
    check(cart_oe == eoe, req, "oe", cart_oe, eoe);
    if (eoe && dknown) check(cart_dout == edo[7:0], req, "dout", cart_dout, edo);
    if (stb) begin
      if (a[12] && ofs < 'h80) begin mram[ofs] = d; mknown[ofs] = 1; end
      if (a[12] && ofs >= 'hFE0 && ofs <= 'hFEF) mbank = ofs & 'hF;
      mlfsr = (mlfsr >> 1) ^ ((mlfsr & 1) ? 'hB400 : 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mknown[i] = 0;
    do_reset();
    cyc(1, 13'h1100, 8'h00, 0, "R4");
    cyc(1, 13'h1ABC, 8'h00, 0, "R2");
    cyc(1, 13'h1FFF, 8'h00, 0, "R2");
    for (int b = 0; b < 16; b++) begin
      cyc(1, 13'h1FE0 | 13'(b), 8'h00, 0, "R3");
      cyc(1, 13'h1234 + 13'(b * 97), 8'h00, 0, "R3");
    end
    cyc(1, 13'h1FE9, 8'h00, 0, "R3");
    cyc(1, 13'h1FE9, 8'h00, 0, "R3");
    cyc(1, 13'h0FE3, 8'h00, 0, "R1");
    cyc(1, 13'h1F00, 8'h00, 0, "R1");
    cyc(0, 13'h1FE7, 8'h00, 0, "R1");
    cyc(1, 13'h1F01, 8'h00, 0, "R1");
    for (int i = 0; i < 128; i++) cyc(1, 13'h1000 | 13'(i), 8'(i * 3 + 1), 0, "R5");
    for (int i = 0; i < 128; i++) cyc(1, 13'h1080 | 13'(i), 8'h00, 0, "R8");
    cyc(1, 13'h0007, 8'hEE, 0, "R1");
    cyc(0, 13'h1007, 8'hDD, 0, "R1");
    cyc(1, 13'h1087, 8'h00, 0, "R1");
    for (int i = 0; i < 8; i++) cyc(1, 13'h1010 + 13'(i), 8'hC0 + 8'(i), 0, "R6");
    for (int i = 0; i < 8; i++) cyc(1, 13'h1090 + 13'(i), 8'h00, 0, "R5");
    for (int i = 0; i < 20; i++) cyc(1, 13'h1020 + 13'(i), 8'h30 + 8'(i), 1, "R7");
    for (int i = 0; i < 20; i++) cyc(1, 13'h10A0 + 13'(i), 8'h00, 1, "R8");
    cyc(1, 13'h1FE6, 8'h00, 0, "R3");
    do_reset();
    cyc(1, 13'h1000, 8'h77, 1, "R9");
    cyc(1, 13'h1001, 8'h78, 1, "R9");
    cyc(1, 13'h1500, 8'h00, 0, "R4");
    for (int i = 0; i < 16; i++) cyc(1, 13'h10C0 + 13'(i), 8'h00, 0, "R4");
    cyc(1, 13'h0055, 8'h00, 1, "R9");
    cyc(1, 13'h1002, 8'h00, 1, "R9");
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule